// File: doc/BRIEF.md
# Endian-Selectable Load/Store Lane Aligner

This block connects a byte-addressed 32-bit load/store port to a memory that is organized as whole words. For a store, it produces the word address, one write enable per byte lane and write data in which the sub-word value is copied into every lane. Only the lanes the object covers are enabled. For a load, it requests the word, then picks the addressed byte or halfword out of the returned word and sign- or zero-extends it. The byte-lane mapping is chosen per request from a mode input that selects big-endian or little-endian ordering.

In big-endian mode, the byte at the lowest address of a word sits in the most significant lane (bits 31:24). In little-endian mode, it sits in the least significant lane (bits 7:0). With this mapping a full word passes through unchanged in either mode. It is therefore identical to the value assembled from four single-byte loads under the same mode.

An access whose address is not a multiple of its size is detected. Such an access never reaches memory, and a flag is raised for one cycle. The block does not split accesses, raise exceptions or speak any bus protocol. It assumes one outstanding load at a time and in-order return.

Top module: `lane_aligner`

## Requirements
- R1: `memAddr` always equals `reqAddr` shifted right by two. An aligned word store enables all four lanes (`memWrEn` = 4'b1111) and passes `storeData` unchanged.
- R2: An aligned byte store (`reqSize` = 2'b00) enables exactly one lane. That lane is the byte offset (`reqAddr[1:0]`) in little-endian mode (`bigEndian` = 0) and 3 minus the offset in big-endian mode. The low byte of `storeData` is copied into all four lanes.
- R3: An aligned halfword store (`reqSize` = 2'b01) enables lanes 1:0 (4'b0011) when offset bit 1 XOR `bigEndian` is 0. Otherwise it enables lanes 3:2 (4'b1100). The low halfword of `storeData` is copied into both halves.
- R4: A byte load returns the lane chosen by the R2 mapping. The result is sign-extended when `reqSigned` is 1 and zero-extended otherwise.
- R5: A halfword load returns bits 31:16 when offset bit 1 XOR `bigEndian` is 1, and bits 15:0 otherwise. It is extended as in R4.
- R6: A word load (`reqSize` = 2'b10) returns the memory word unchanged. In both modes, this equals the word assembled from four byte loads of its addresses: the lowest address is most significant in big-endian mode and least significant in little-endian mode.
- R7: An access is misaligned when any of these hold: `reqSize` = 2'b11; a halfword has offset bit 0 set; a word has a nonzero offset. A misaligned request raises `misalign` in the following cycle only.
- R8: A misaligned access issues no memory activity: `memWrEn` = 0 and `memRead` = 0. A write enable is only ever raised for a store request, and `memRead` only for a load request.
- R9: A misaligned load produces `loadValid` = 1 with `loadData` = 0 in the cycle after the request.
- R10: An aligned load raises `loadValid` exactly one cycle after `memRdValid`. It uses the size, offset, sign and mode captured when it was issued, even if those inputs change while it waits. A `memRdValid` with no load pending produces no result.
- R11: While `rstN` is low, `loadValid`, `loadData` and `misalign` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Access request this cycle |
| reqAddr | input | ADDR_W | Byte address |
| reqSize | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| reqStore | input | 1 | 1 store, 0 load |
| reqSigned | input | 1 | Sign-extend sub-word loads |
| bigEndian | input | 1 | 1 big-endian lane order, 0 little-endian |
| storeData | input | 32 | Store value, right-justified |
| memAddr | output | ADDR_W-2 | Word address to memory |
| memRead | output | 1 | Read request to memory |
| memWrEn | output | 4 | Per-lane write enables |
| memWrData | output | 32 | Lane-steered write data |
| memRdValid | input | 1 | Memory read data valid |
| memRdData | input | 32 | Memory read word |
| loadValid | output | 1 | Load result valid |
| loadData | output | 32 | Extended load result |
| misalign | output | 1 | One-cycle misaligned-access flag |

## Verification
The hardest case to reach from the ports is a load whose attributes change while it waits for memory. If the block read its live inputs instead of the values captured at issue, the result would differ only when the mode, size or offset changed in exactly that gap. The stimulus therefore drives random size, mode and sign values on the idle request inputs while every load is outstanding. It also injects a read-valid pulse with no load pending. Beyond that, random accesses with every size, offset and mode are mixed with directed sequences that store four bytes and read back the word in each mode.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;
  localparam int WORD_BYTES = 4;
  localparam int BYTE_W     = 8;
  localparam int WORD_W     = WORD_BYTES * BYTE_W;
  localparam int HALF_W     = WORD_W / 2;
  localparam int OFF_W      = $clog2(WORD_BYTES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } accSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic issueRead;
    logic issueWrite;
    logic captureLoad;
    logic zeroLoad;
    logic extractLoad;
  } ctrlStrobe_t;
endpackage

// File: rtl/align_ctrl.sv
module align_ctrl
  import lane_align_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqStore,
  input  logic [1:0]        reqSize,
  input  logic [OFF_W-1:0]  reqOff,
  input  logic              memRdValid,
  output ctrlStrobe_t       strobe,
  output logic              misalign
);
  accSize_e sizeE;
  logic     badAccess;
  logic     pendValid;

  assign sizeE = accSize_e'(reqSize);

  // alignment rule: offset must be a multiple of object size
  always_comb begin
    case (sizeE)
      SZ_BYTE: badAccess = 1'b0;
      SZ_HALF: badAccess = reqOff[0];
      SZ_WORD: badAccess = |reqOff;
      default: badAccess = 1'b1;
    endcase
  end

  always_comb begin
    strobe.issueRead   = reqValid & ~reqStore & ~badAccess;
    strobe.issueWrite  = reqValid &  reqStore & ~badAccess;
    strobe.captureLoad = reqValid & ~reqStore & ~badAccess;
    strobe.zeroLoad    = reqValid & ~reqStore &  badAccess;
    strobe.extractLoad = memRdValid & pendValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      misalign  <= 1'b0;
    end else begin
      misalign <= reqValid & badAccess;
      if (strobe.captureLoad)      pendValid <= 1'b1;
      else if (strobe.extractLoad) pendValid <= 1'b0;
    end
  end
endmodule

// File: rtl/align_datapath.sv
module align_datapath
  import lane_align_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [1:0]           reqSize,
  input  logic                 reqSigned,
  input  logic                 bigEndian,
  input  logic [WORD_W-1:0]    storeData,
  input  logic [WORD_W-1:0]    memRdData,
  output logic [ADDR_W-OFF_W-1:0] memAddr,
  output logic                 memRead,
  output logic [WORD_BYTES-1:0] memWrEn,
  output logic [WORD_W-1:0]    memWrData,
  output logic                 loadValid,
  output logic [WORD_W-1:0]    loadData
);
  accSize_e         sizeE;
  logic [OFF_W-1:0] reqOff;
  logic [OFF_W-1:0] laneSel;
  logic             halfUpper;

  assign sizeE     = accSize_e'(reqSize);
  assign reqOff    = reqAddr[OFF_W-1:0];
  assign laneSel   = reqOff ^ {OFF_W{bigEndian}};
  assign halfUpper = reqOff[OFF_W-1] ^ bigEndian;
  assign memAddr   = reqAddr[ADDR_W-1:OFF_W];
  assign memRead   = strobe.issueRead;

  // store lane steering
  logic [BYTE_W-1:0] rdBytes [WORD_BYTES];

  for (genvar i = 0; i < WORD_BYTES; i++) begin : gLane
    localparam bit IN_UPPER = (i >= WORD_BYTES / 2);
    logic laneHit;
    always_comb begin
      case (sizeE)
        SZ_BYTE: laneHit = (laneSel == OFF_W'(i));
        SZ_HALF: laneHit = (IN_UPPER == halfUpper);
        SZ_WORD: laneHit = 1'b1;
        default: laneHit = 1'b0;
      endcase
    end
    assign memWrEn[i] = strobe.issueWrite & laneHit;
    assign rdBytes[i] = memRdData[i*BYTE_W +: BYTE_W];
  end

  always_comb begin
    case (sizeE)
      SZ_BYTE: memWrData = {WORD_BYTES{storeData[BYTE_W-1:0]}};
      SZ_HALF: memWrData = {2{storeData[HALF_W-1:0]}};
      default: memWrData = storeData;
    endcase
  end

  // attributes of the outstanding load
  logic [OFF_W-1:0] pOff;
  accSize_e         pSize;
  logic             pSigned;
  logic             pBig;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pOff    <= '0;
      pSize   <= SZ_BYTE;
      pSigned <= 1'b0;
      pBig    <= 1'b0;
    end else if (strobe.captureLoad) begin
      pOff    <= reqOff;
      pSize   <= sizeE;
      pSigned <= reqSigned;
      pBig    <= bigEndian;
    end
  end

  // load extraction and extension
  logic [OFF_W-1:0]  pLane;
  logic              pUpper;
  logic [BYTE_W-1:0] pickByte;
  logic [HALF_W-1:0] pickHalf;
  logic [WORD_W-1:0] extWord;

  assign pLane    = pOff ^ {OFF_W{pBig}};
  assign pUpper   = pOff[OFF_W-1] ^ pBig;
  assign pickByte = rdBytes[pLane];
  assign pickHalf = pUpper ? memRdData[WORD_W-1 -: HALF_W] : memRdData[HALF_W-1:0];

  always_comb begin
    case (pSize)
      SZ_BYTE: extWord = {{(WORD_W-BYTE_W){pSigned & pickByte[BYTE_W-1]}}, pickByte};
      SZ_HALF: extWord = {{(WORD_W-HALF_W){pSigned & pickHalf[HALF_W-1]}}, pickHalf};
      default: extWord = memRdData;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadValid <= 1'b0;
      loadData  <= '0;
    end else if (strobe.zeroLoad) begin
      loadValid <= 1'b1;
      loadData  <= '0;
    end else if (strobe.extractLoad) begin
      loadValid <= 1'b1;
      loadData  <= extWord;
    end else begin
      loadValid <= 1'b0;
    end
  end
endmodule

// File: rtl/lane_aligner.sv
module lane_aligner
  import lane_align_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqStore,
  input  logic              reqSigned,
  input  logic              bigEndian,
  input  logic [31:0]       storeData,
  output logic [ADDR_W-3:0] memAddr,
  output logic              memRead,
  output logic [3:0]        memWrEn,
  output logic [31:0]       memWrData,
  input  logic              memRdValid,
  input  logic [31:0]       memRdData,
  output logic              loadValid,
  output logic [31:0]       loadData,
  output logic              misalign
);
  ctrlStrobe_t strobe;

  align_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqStore   (reqStore),
    .reqSize    (reqSize),
    .reqOff     (reqAddr[OFF_W-1:0]),
    .memRdValid (memRdValid),
    .strobe     (strobe),
    .misalign   (misalign)
  );

  align_datapath #(.ADDR_W(ADDR_W)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqAddr   (reqAddr),
    .reqSize   (reqSize),
    .reqSigned (reqSigned),
    .bigEndian (bigEndian),
    .storeData (storeData),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .memRead   (memRead),
    .memWrEn   (memWrEn),
    .memWrData (memWrData),
    .loadValid (loadValid),
    .loadData  (loadData)
  );
endmodule

// File: rtl/lane_aligner_checker.sv
module lane_aligner_checker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [1:0]  reqSize,
  input logic        reqStore,
  input logic [31:0] storeData,
  input logic        memRead,
  input logic [3:0]  memWrEn,
  input logic [31:0] memWrData,
  input logic        memRdValid,
  input logic        loadValid,
  input logic [31:0] loadData,
  input logic        misalign
);
  assert_word_lanes_R1: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn != 4'b0000 && reqSize == 2'b10) |-> (memWrEn == 4'b1111 && memWrData == storeData));

  assert_byte_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn != 4'b0000 && reqSize == 2'b00) |-> ($countones(memWrEn) == 1));

  assert_half_pair_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn != 4'b0000 && reqSize == 2'b01) |-> ($countones(memWrEn) == 2));

  assert_write_only_store_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn != 4'b0000) |-> (reqValid && reqStore && !memRead));

  assert_read_only_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    memRead |-> (reqValid && !reqStore));

  assert_reserved_silent_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize == 2'b11) |-> (memWrEn == 4'b0000 && !memRead));

  assert_flag_after_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    misalign |-> $past(reqValid));

  assert_zero_bad_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && misalign) |-> (loadData == 32'd0));

  assert_result_after_return_R10: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && !misalign) |-> $past(memRdValid));
endmodule

bind lane_aligner lane_aligner_checker uChecker (.*);

// File: tb/lane_aligner_test.sv
module lane_aligner_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqStore, reqSigned, bigEndian;
  logic [31:0] reqAddr, storeData;
  logic [1:0]  reqSize;
  logic [29:0] memAddr;
  logic        memRead;
  logic [3:0]  memWrEn;
  logic [31:0] memWrData;
  logic        memRdValid, memRdValidQ, strayValid;
  logic [31:0] memRdData;
  logic        loadValid, misalign;
  logic [31:0] loadData;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  lane_aligner uut (.*);

  // word memory model, one-cycle read latency
  logic [31:0] wordMem [16];
  assign memRdValid = memRdValidQ | strayValid;

  always_ff @(posedge clk) begin
    memRdValidQ <= memRead;
    if (memRead) memRdData <= wordMem[memAddr[3:0]];
    for (int i = 0; i < 4; i++)
      if (memWrEn[i]) wordMem[memAddr[3:0]][8*i +: 8] <= memWrData[8*i +: 8];
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit isBad(logic [1:0] sz, logic [1:0] off);
    case (sz)
      2'b00:   return 1'b0;
      2'b01:   return off[0];
      2'b10:   return off != 2'b00;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [3:0] expEn(logic [1:0] sz, logic [1:0] off, bit be);
    int lane = be ? 3 - int'(off) : int'(off);
    if (isBad(sz, off)) return 4'b0000;
    case (sz)
      2'b00:   return 4'b0001 << lane;
      2'b01:   return (off[1] ^ be) ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] expWr(logic [1:0] sz, logic [31:0] d);
    case (sz)
      2'b00:   return {4{d[7:0]}};
      2'b01:   return {2{d[15:0]}};
      default: return d;
    endcase
  endfunction

  function automatic logic [31:0] expLoad(logic [31:0] w, logic [1:0] sz, logic [1:0] off, bit be, bit sg);
    int lane = be ? 3 - int'(off) : int'(off);
    logic [7:0]  b = w[8*lane +: 8];
    logic [15:0] h = (off[1] ^ be) ? w[31:16] : w[15:0];
    case (sz)
      2'b00:   return sg ? {{24{b[7]}}, b} : {24'd0, b};
      2'b01:   return sg ? {{16{h[15]}}, h} : {16'd0, h};
      default: return w;
    endcase
  endfunction

  task automatic idle();
    reqValid = 0; reqStore = 0; reqAddr = '0; reqSize = 0;
    reqSigned = 0; storeData = '0; bigEndian = 0;
  endtask

  task automatic access(logic [31:0] a, logic [1:0] sz, bit st, bit sg, bit be,
                        logic [31:0] d, output logic [31:0] got);
    bit bad = isBad(sz, a[1:0]);
    logic [31:0] expL = expLoad(wordMem[a[5:2]], sz, a[1:0], be, sg);
    got = '0;
    @(negedge clk);
    reqValid = 1; reqAddr = a; reqSize = sz; reqStore = st;
    reqSigned = sg; bigEndian = be; storeData = d;
    #1;
    chk(memAddr == a[31:2], "R1 word address", 32'(memAddr), 32'(a[31:2]));
    if (st) begin
      chk(memWrEn == expEn(sz, a[1:0], be), bad ? "R8 no write" : (sz == 2'b00) ? "R2 byte enable" :
          (sz == 2'b01) ? "R3 half enable" : "R1 word enable", 32'(memWrEn), 32'(expEn(sz, a[1:0], be)));
      if (!bad)
        chk(memWrData == expWr(sz, d), (sz == 2'b00) ? "R2 data" : (sz == 2'b01) ? "R3 data" : "R1 data",
            memWrData, expWr(sz, d));
    end
    chk(memRead == (!st && !bad), "R8 read request", 32'(memRead), 32'(!st && !bad));
    @(negedge clk);
    // scramble idle request inputs while any load is outstanding (R10)
    reqValid = 0; reqSize = 2'($urandom); bigEndian = 1'($urandom);
    reqSigned = 1'($urandom); reqAddr = $urandom;
    chk(misalign == bad, "R7 flag", 32'(misalign), 32'(bad));
    if (!st && bad) begin
      chk(loadValid == 1'b1, "R9 valid", 32'(loadValid), 32'd1);
      chk(loadData == 32'd0, "R9 zero data", loadData, 32'd0);
    end else begin
      chk(loadValid == 1'b0, "R10 no early result", 32'(loadValid), 32'd0);
    end
    if (!st && !bad) begin
      @(negedge clk);
      chk(loadValid == 1'b1, "R10 result timing", 32'(loadValid), 32'd1);
      chk(loadData == expL, (sz == 2'b00) ? "R4 byte load" : (sz == 2'b01) ? "R5 half load" : "R6 word load",
          loadData, expL);
      got = loadData;
    end
    if (bad) begin
      @(negedge clk);
      chk(misalign == 1'b0, "R7 single cycle", 32'(misalign), 32'd0);
    end
  endtask

  initial begin
    #(5ns * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] got;
    void'($urandom(32'd20011));
    strayValid = 0;
    for (int i = 0; i < 16; i++) wordMem[i] = 32'h1000_0000 * i + 32'h0102_0304;
    idle();
    rstN = 0;
    repeat (3) @(negedge clk);
    chk(loadValid == 1'b0, "R11 valid", 32'(loadValid), 32'd0);
    chk(loadData == 32'd0, "R11 data", loadData, 32'd0);
    chk(misalign == 1'b0, "R11 flag", 32'(misalign), 32'd0);
    rstN = 1;
    @(negedge clk);

    // directed: four byte stores then word load, both modes (R6)
    for (int m = 0; m < 2; m++) begin
      logic [31:0] expW;
      for (int k = 0; k < 4; k++)
        access(32'h20 + k, 2'b00, 1, 0, m[0], 32'hA0 + k, got);
      expW = m[0] ? 32'hA0A1A2A3 : 32'hA3A2A1A0;
      access(32'h20, 2'b10, 0, 0, m[0], 0, got);
      chk(got == expW, "R6 assembled word", got, expW);
    end

    // directed corner cases
    access(32'hFFFF_FFFC, 2'b10, 1, 0, 1, 32'hDEAD_BEEF, got);  // R1 top address
    access(32'h0000_0013, 2'b01, 1, 0, 0, 32'h1234, got);       // R7 odd half
    access(32'h0000_0016, 2'b10, 0, 1, 1, 0, got);               // R9 bad word load
    access(32'h0000_0014, 2'b11, 0, 0, 0, 0, got);               // R7 reserved size
    access(32'h0000_0030, 2'b00, 1, 0, 1, 32'h0000_0080, got);   // R4 sign bit byte
    access(32'h0000_0030, 2'b00, 0, 1, 1, 0, got);               // R4 signed byte
    access(32'h0000_0032, 2'b01, 0, 1, 0, 0, got);               // R5 upper half LE

    // stray read-valid with nothing pending (R10)
    @(negedge clk); strayValid = 1;
    @(negedge clk); strayValid = 0;
    chk(loadValid == 1'b0, "R10 stray ignored", 32'(loadValid), 32'd0);

    // constrained random
    for (int n = 0; n < 600; n++) begin
      logic [1:0]  sz = ($urandom % 8 == 0) ? 2'b11 : 2'($urandom % 3);
      logic [31:0] a  = {26'd0, 6'($urandom)};
      if ($urandom % 4 != 0) begin
        if (sz == 2'b01) a[0] = 1'b0;
        if (sz == 2'b10) a[1:0] = 2'b00;
      end
      access(a, sz, 1'($urandom), 1'($urandom), 1'($urandom), $urandom, got);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule